// File: doc/BRIEF.md
# Auto-refresh scheduler

This block decides when a DDR2-style memory controller must spend a bus slot on an auto-refresh. A free-running interval timer divides the retention window (expressed in clock cycles) by the number of rows. This gives the average refresh interval. Each expiry of that timer adds one owed refresh to a small saturating backlog. While anything is owed, the block raises a request towards the controller's command arbiter.

A refresh is launched only when three conditions meet at one clock edge. The arbiter must grant the bus. The backlog must be non-zero. Every bank must be reported idle at that edge and at each of the preceding `trp_cycles` edges. The command pins then carry the refresh encoding for exactly one cycle. The address bus is not driven, because the memory's internal counter picks the row. In every other cycle the pins hold the no-operation pattern. A full backlog raises an urgent flag, so that the arbiter can stop postponing.

Top module: `rfsh_scheduler`

## Requirements
- R1: While reset is asserted and after it is released, the pins show no-operation (cs_n=0, ras_n=1, cas_n=1, we_n=1) and ref_req and ref_urgent are 0 until the first interval expires.
- R2: The interval is REFI = RETENTION_CYCLES / NUM_ROWS cycles. ref_req is 0 after REFI-1 rising edges following reset release and 1 after REFI edges when nothing is issued. Each further REFI edges add one owed refresh.
- R3: ref_req is 1 exactly when the backlog is non-zero. A refresh only follows a cycle in which ref_req was 1.
- R4: A refresh command is cs_n=0, ras_n=0, cas_n=0, we_n=1 for one cycle. It appears in the cycle after the launching edge.
- R5: A refresh is launched only when every bit of bank_idle was 1 at the launching edge and at the trp_cycles edges before it. If one bank is busy, no refresh is launched.
- R6: No refresh is launched at an edge where grant is 0, however long the backlog has been owed.
- R7: The backlog holds at most 8 owed refreshes. ref_urgent is 1 exactly when it is full, and expiries while full are dropped. After a full backlog, exactly 8 refreshes are issued before ref_req falls.
- R8: When an interval expiry and a launch fall on the same edge, the backlog keeps its value, so ref_req stays 1.
- R9: A launch restarts the idle window. With banks idle and grant held, successive refreshes are trp_cycles+1 edges apart.
- R10: In every cycle that is not a refresh cycle, the pins show the no-operation pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_idle | input | NUM_BANKS | Per-bank flag: 1 when the bank is precharged and idle |
| trp_cycles | input | TRP_W | Required idle window before a refresh, in cycles |
| grant | input | 1 | Command bus granted to the refresh path |
| ref_req | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | Backlog full, refresh must not be postponed further |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The interval timer can expire on the same edge at which a refresh is launched. The backlog must then add and remove one owed refresh together and stay unchanged. The bench provokes this deliberately: it withholds grant until one refresh is owed, then raises grant one cycle before the next expiry. It judges the result by ref_req staying high and a second refresh following trp_cycles+1 edges later. Long random stretches of grant and bank activity also produce the overlap, and a counter in the bench's reference model proves it occurred.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } ddr_cmd_t;

   localparam ddr_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam ddr_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
   parameter int unsigned PERIOD = 781
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign tick = (cnt_q == LAST);

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
   parameter int unsigned MAX_POSTPONE = 8,
   parameter int unsigned BACKLOG_W    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 add,
   input  logic                 take,
   output logic [BACKLOG_W-1:0] count,
   output logic                 nonzero,
   output logic                 full
);
   localparam logic [BACKLOG_W-1:0] TOP = BACKLOG_W'(MAX_POSTPONE);

   logic [BACKLOG_W-1:0] cnt_q;
   logic [BACKLOG_W-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      unique case ({add, take})
         2'b10: if (cnt_q != TOP) cnt_d = cnt_q + BACKLOG_W'(1);
         2'b01: if (cnt_q != '0)  cnt_d = cnt_q - BACKLOG_W'(1);
         default: cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign count   = cnt_q;
   assign nonzero = (cnt_q != '0);
   assign full    = (cnt_q == TOP);

endmodule

// File: rtl/rfsh_idle_gate.sv
module rfsh_idle_gate #(
   parameter int unsigned NUM_BANKS      = 4,
   parameter int unsigned TRP_W          = 5,
   parameter bit          PER_BANK_COUNT = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] bank_idle,
   input  logic [TRP_W-1:0]     trp_cycles,
   input  logic                 restart,
   output logic                 all_ready
);
   localparam logic [TRP_W-1:0] SAT = '1;

   generate
      if (PER_BANK_COUNT) begin : g_per_bank
         logic [NUM_BANKS-1:0] ready;
         for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic [TRP_W-1:0] run_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  run_q <= '0;
               end else if (restart || !bank_idle[b]) begin
                  run_q <= '0;
               end else if (run_q != SAT) begin
                  run_q <= run_q + TRP_W'(1);
               end
            end
            assign ready[b] = bank_idle[b] && (run_q >= trp_cycles);
         end
         assign all_ready = &ready;
      end else begin : g_shared
         logic             idle_all;
         logic [TRP_W-1:0] run_q;
         assign idle_all = &bank_idle;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
            end else if (restart || !idle_all) begin
               run_q <= '0;
            end else if (run_q != SAT) begin
               run_q <= run_q + TRP_W'(1);
            end
         end
         assign all_ready = idle_all && (run_q >= trp_cycles);
      end
   endgenerate

endmodule

// File: rtl/rfsh_scheduler.sv
module rfsh_scheduler #(
   parameter int unsigned RETENTION_CYCLES = 6400000,
   parameter int unsigned NUM_ROWS         = 8192,
   parameter int unsigned NUM_BANKS        = 4,
   parameter int unsigned MAX_POSTPONE     = 8,
   parameter int unsigned TRP_W            = 5,
   parameter bit          PER_BANK_COUNT   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] bank_idle,
   input  logic [TRP_W-1:0]     trp_cycles,
   input  logic                 grant,
   output logic                 ref_req,
   output logic                 ref_urgent,
   output logic                 cs_n,
   output logic                 ras_n,
   output logic                 cas_n,
   output logic                 we_n
);
   import rfsh_pkg::*;

   localparam int unsigned REFI      = RETENTION_CYCLES / NUM_ROWS;
   localparam int unsigned BACKLOG_W = $clog2(MAX_POSTPONE + 1);

   generate
      if (NUM_ROWS == 0 || REFI < 2) begin : g_bad_interval
         $error("rfsh_scheduler: refresh interval must be at least 2 cycles");
      end
      if (NUM_BANKS < 1) begin : g_bad_banks
         $error("rfsh_scheduler: NUM_BANKS must be at least 1");
      end
      if (MAX_POSTPONE < 1) begin : g_bad_backlog
         $error("rfsh_scheduler: MAX_POSTPONE must be at least 1");
      end
      if (TRP_W < 1) begin : g_bad_trp
         $error("rfsh_scheduler: TRP_W must be at least 1");
      end
   endgenerate

   logic                 tick;
   logic                 issue;
   logic                 owed;
   logic                 full;
   logic                 all_ready;
   logic [BACKLOG_W-1:0] backlog;
   ddr_cmd_t             cmd_q;

   rfsh_interval_timer #(
      .PERIOD (REFI)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   rfsh_backlog #(
      .MAX_POSTPONE (MAX_POSTPONE),
      .BACKLOG_W    (BACKLOG_W)
   ) u_backlog (
      .clk     (clk),
      .rst_n   (rst_n),
      .add     (tick),
      .take    (issue),
      .count   (backlog),
      .nonzero (owed),
      .full    (full)
   );

   rfsh_idle_gate #(
      .NUM_BANKS      (NUM_BANKS),
      .TRP_W          (TRP_W),
      .PER_BANK_COUNT (PER_BANK_COUNT)
   ) u_idle (
      .clk        (clk),
      .rst_n      (rst_n),
      .bank_idle  (bank_idle),
      .trp_cycles (trp_cycles),
      .restart    (issue),
      .all_ready  (all_ready)
   );

   assign issue = owed && grant && all_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= CMD_NOP;
      end else begin
         cmd_q <= issue ? CMD_REF : CMD_NOP;
      end
   end

   assign ref_req    = owed;
   assign ref_urgent = full;
   assign cs_n       = cmd_q.cs_n;
   assign ras_n      = cmd_q.ras_n;
   assign cas_n      = cmd_q.cas_n;
   assign we_n       = cmd_q.we_n;

endmodule

// File: rtl/rfsh_scheduler_chk.sv
module rfsh_scheduler_chk #(
   parameter int unsigned NUM_BANKS    = 4,
   parameter int unsigned MAX_POSTPONE = 8,
   parameter int unsigned BACKLOG_W    = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_BANKS-1:0] bank_idle,
   input logic                 grant,
   input logic                 ref_req,
   input logic                 ref_urgent,
   input logic                 cs_n,
   input logic                 ras_n,
   input logic                 cas_n,
   input logic                 we_n,
   input logic                 tick,
   input logic                 issue,
   input logic [BACKLOG_W-1:0] backlog
);
   localparam logic [BACKLOG_W-1:0] TOP = BACKLOG_W'(MAX_POSTPONE);

   // R6
   ref_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> $past(grant));

   // R5
   ref_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> $past(&bank_idle));

   // R3
   ref_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> $past(ref_req));

   // R4
   ref_encoding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> (!cs_n && !ras_n && we_n));

   // R10
   nop_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cas_n |-> (!cs_n && ras_n && we_n));

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      backlog <= TOP);

   // R7
   urgent_implies_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_urgent |-> ref_req);

   // R8
   tick_issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && issue) |=> (backlog == $past(backlog)));

   // R2
   tick_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !issue && (backlog != TOP)) |=> (backlog == $past(backlog) + BACKLOG_W'(1)));

endmodule

bind rfsh_scheduler rfsh_scheduler_chk #(
   .NUM_BANKS    (NUM_BANKS),
   .MAX_POSTPONE (MAX_POSTPONE),
   .BACKLOG_W    (BACKLOG_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bank_idle  (bank_idle),
   .grant      (grant),
   .ref_req    (ref_req),
   .ref_urgent (ref_urgent),
   .cs_n       (cs_n),
   .ras_n      (ras_n),
   .cas_n      (cas_n),
   .we_n       (we_n),
   .tick       (tick),
   .issue      (issue),
   .backlog    (backlog)
);

// File: tb/tb_rfsh_scheduler.sv
module tb_rfsh_scheduler;
   localparam int unsigned RET  = 4000;
   localparam int unsigned ROWS = 40;
   localparam int          REFI = 100;
   localparam int unsigned NB   = 4;
   localparam int          MAXP = 8;
   localparam int unsigned TW   = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB-1:0] bank_idle = '1;
   logic [TW-1:0] trp = 5'd6;
   logic          grant = 1'b0;
   logic          ref_req, ref_urgent, cs_n, ras_n, cas_n, we_n;

   always #5 clk = ~clk;

   rfsh_scheduler #(
      .RETENTION_CYCLES (RET),
      .NUM_ROWS         (ROWS),
      .NUM_BANKS        (NB),
      .MAX_POSTPONE     (MAXP),
      .TRP_W            (TW),
      .PER_BANK_COUNT   (1'b1)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bank_idle  (bank_idle),
      .trp_cycles (trp),
      .grant      (grant),
      .ref_req    (ref_req),
      .ref_urgent (ref_urgent),
      .cs_n       (cs_n),
      .ras_n      (ras_n),
      .cas_n      (cas_n),
      .we_n       (we_n)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   int dut_refs = 0;
   int cyc = 0;

   // reference model state
   int m_timer = 0;
   int m_backlog = 0;
   int m_idle = 0;
   bit m_ref = 0;
   int overlap_cnt = 0;

   function automatic int next_backlog(int b, bit tk, bit is);
      if (tk && !is) return (b < MAXP) ? b + 1 : b;
      if (is && !tk) return b - 1;
      return b;
   endfunction

   function automatic bit window_ok(logic [NB-1:0] idle, int run, int need);
      return (&idle) && (run >= need);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_timer <= 0; m_backlog <= 0; m_idle <= 0; m_ref <= 0;
      end else begin
         bit tk;
         bit is;
         tk = (m_timer == REFI - 1);
         is = (m_backlog != 0) && grant && window_ok(bank_idle, m_idle, int'(trp));
         m_timer   <= tk ? 0 : m_timer + 1;
         m_backlog <= next_backlog(m_backlog, tk, is);
         m_idle    <= (is || !(&bank_idle)) ? 0 : ((m_idle < 31) ? m_idle + 1 : m_idle);
         m_ref     <= is;
         if (tk && is) overlap_cnt <= overlap_cnt + 1;
      end
   end

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
      end
   endtask

   task automatic compare_all();
      logic [3:0] act;
      logic [3:0] exp;
      act = {cs_n, ras_n, cas_n, we_n};
      exp = m_ref ? 4'b0001 : 4'b0111;
      check(ref_req == (m_backlog != 0), "R3 ref_req", int'(ref_req), int'(m_backlog != 0));
      check(ref_urgent == (m_backlog == MAXP), "R7 ref_urgent", int'(ref_urgent), int'(m_backlog == MAXP));
      check(act == exp, m_ref ? "R4 refresh pins" : "R10 nop pins", int'(act), int'(exp));
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      cyc++;
      compare_all();
      if (!cas_n) dut_refs++;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog (R1..R10 run): actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      int t1;
      int t2;
      int base;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 pins in reset", int'({cs_n, ras_n, cas_n, we_n}), 7);
      check(ref_req == 1'b0, "R1 ref_req in reset", int'(ref_req), 0);
      check(ref_urgent == 1'b0, "R1 ref_urgent in reset", int'(ref_urgent), 0);
      rst_n = 1'b1;

      // R2: first interval expiry
      repeat (REFI - 1) step();
      check(ref_req == 1'b0, "R2 no request before interval", int'(ref_req), 0);
      step();
      check(ref_req == 1'b1, "R2 request at interval", int'(ref_req), 1);

      // R6: owed but no grant
      repeat (10) step();
      check(dut_refs == 0, "R6 no refresh without grant", dut_refs, 0);

      // R5: one bank busy, then a short idle window
      bank_idle = 4'b1011;
      grant = 1'b1;
      repeat (20) step();
      check(dut_refs == 0, "R5 busy bank blocks refresh", dut_refs, 0);
      bank_idle = '1;
      repeat (6) step();
      check(dut_refs == 0, "R5 idle window too short", dut_refs, 0);
      step();
      check(cas_n == 1'b0, "R5 refresh after full window", int'(cas_n), 0);
      check(ref_req == 1'b0, "R3 request cleared after refresh", int'(ref_req), 0);

      // R9: two owed refreshes spaced by trp+1
      grant = 1'b0;
      repeat (2 * REFI) step();
      grant = 1'b1;
      t1 = -1; t2 = -1;
      for (int i = 0; i < 60; i++) begin
         step();
         if (!cas_n) begin
            if (t1 < 0) t1 = cyc;
            else if (t2 < 0) t2 = cyc;
         end
      end
      check((t2 - t1) == int'(trp) + 1, "R9 refresh spacing", t2 - t1, int'(trp) + 1);

      // R7: saturation and drain
      grant = 1'b0;
      repeat (10 * REFI) step();
      for (int i = 0; i < 2 * REFI && m_timer != 0; i++) step();
      check(ref_urgent == 1'b1, "R7 urgent when full", int'(ref_urgent), 1);
      base = dut_refs;
      grant = 1'b1;
      repeat (60) step();
      check(dut_refs - base == MAXP, "R7 postponed refreshes drained", dut_refs - base, MAXP);
      check(ref_req == 1'b0, "R7 request falls after drain", int'(ref_req), 0);

      // R8: launch on the same edge as an expiry
      grant = 1'b0;
      for (int i = 0; i < 4 * REFI && !(m_backlog == 1 && m_timer == REFI - 1); i++) step();
      grant = 1'b1;
      step();
      check(cas_n == 1'b0, "R8 refresh at expiry edge", int'(cas_n), 0);
      check(ref_req == 1'b1, "R8 backlog held", int'(ref_req), 1);
      repeat (int'(trp) + 1) step();
      check(cas_n == 1'b0, "R8 second refresh follows", int'(cas_n), 0);

      // random mix
      for (int blk = 0; blk < 80; blk++) begin
         int busy_div;
         busy_div = (($urandom % 4) == 0) ? 4 : 64;
         for (int i = 0; i < 64; i++) begin
            grant = (($urandom % 3) != 0);
            for (int b = 0; b < int'(NB); b++) bank_idle[b] = (($urandom % busy_div) != 0);
            if (($urandom % 50) == 0) trp = TW'($urandom % 8);
            step();
         end
      end
      check(overlap_cnt > 0, "R8 overlap exercised", overlap_cnt, 1);

      finished = 1;
      summary();
      $finish;
   end

endmodule